// File: doc/BRIEF.md
# Character Pattern Bank Mapper with Per-Window ROM/RAM Select

This block translates addresses on the video side of a tile-based display system into banked addresses for character pattern memory. A CPU-side register port stores a pointer register and six character bank registers. The pointer register holds a target index and an inversion flag. The 8 KB pattern space, addressed by the video bus, is split into two 2 KB windows and four 1 KB windows. Each window takes its bank from one of the six registers. The inversion flag swaps the lower and upper 4 KB halves of this arrangement.

Each bank register also holds a memory-select bit. This bit chooses whether its window reads from character ROM or from character RAM. Because the choice is made per window, ROM tiles and RAM tiles can appear side by side in the same pattern space. The block drives one enable for each memory. It drives neither enable when the video address lies outside the pattern space, which is the nametable region.

The register port is synchronous. Translation is purely combinational, so a video lookup sees the register state present at that moment.

Top module: `chr_bank_mapper`

## Requirements
- R1: A write with the strobe high changes the register state only when the CPU address is in $8000-$9FFF. A write to any other address has no effect.
- R2: A write to an even address in that range loads the pointer register. Data bits 2:0 give the target index and data bit 7 gives the inversion flag.
- R3: A write to an odd address in that range stores data bits 6:0 into the bank register named by the target index (0 to 5). Data bit 7 is discarded.
- R4: An odd-address write while the target index is 6 or 7 leaves every character register unchanged.
- R5: When the inversion flag is 0, register 0 maps video $0000-$07FF and register 1 maps video $0800-$0FFF. For these windows the output address is {bank[5:1], A10, A9:A0}, so bank bit 0 is ignored.
- R6: When the inversion flag is 0, registers 2 to 5 map the 1 KB windows at video $1000, $1400, $1800 and $1C00. For these windows the output address is {bank[5:0], A9:A0}.
- R7: When the inversion flag is 1, the two halves swap. Registers 0 and 1 map $1000-$17FF and $1800-$1FFF, and registers 2 to 5 map $0000, $0400, $0800 and $0C00. The address formats stay the same.
- R8: Bit 6 of the selected bank register picks the memory: 0 asserts the ROM enable and 1 asserts the RAM enable. The two enables are never asserted together, and the choice is made independently for each window.
- R9: When video A13 is 1, both memory enables are deasserted.
- R10: Reset clears the pointer register and all bank registers. After reset, every window addresses bank 0 of ROM.
- R11: A register write becomes visible at the outputs right after the clock edge on which it is strobed. The outputs follow a change of the video address without any clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| vid_addr | input | 14 | Video address |
| chr_addr | output | 16 | Banked character memory address |
| rom_ce | output | 1 | Character ROM enable |
| ram_ce | output | 1 | Character RAM enable |

## Verification
A wrong register value or a misplaced write shows up as soon as the video address reaches the window that uses the affected register. The banked address is wrong in its upper bits, or the wrong memory enable is asserted. A stuck inversion flag moves whole 4 KB halves to the wrong place. Because translation is combinational, each fault can be seen in the first cycle after the offending write, provided the right window is being addressed. For this reason the bench sweeps the whole video space after every group of writes and compares against a behavioural model on every clock.

// File: rtl/chr_map_pkg.sv
package chr_map_pkg;
   localparam int unsigned BANK_W   = 6;
   localparam int unsigned WIN_W    = 10;
   localparam int unsigned VID_W    = 14;
   localparam int unsigned CHR_REGS = 6;
   localparam int unsigned IDX_W    = 3;
   localparam int unsigned DATA_W   = 8;
   localparam int unsigned CS_BIT   = 6;

   typedef struct packed {
      logic              ram;
      logic [BANK_W-1:0] num;
   } chr_bank_t;
endpackage

// File: rtl/chr_bank_regs.sv
module chr_bank_regs
   import chr_map_pkg::*;
#(
   parameter int unsigned NREG  = CHR_REGS,
   parameter int unsigned IW    = IDX_W,
   parameter int unsigned DW    = DATA_W,
   parameter int unsigned CSB   = CS_BIT
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  we,
   input  logic [15:0]           addr,
   input  logic [DW-1:0]         data,
   output chr_bank_t [NREG-1:0]  bank_q,
   output logic                  inv_q
);
   logic [IW-1:0] idx_q;
   logic          hit, sel_wr, dat_wr;

   initial begin
      assert (NREG <= (1 << IW)) else $error("register count exceeds index range");
      assert (CSB < DW && BANK_W <= CSB) else $error("chip-select bit placement invalid");
   end

   assign hit    = we && (addr[15:13] == 3'b100);
   assign sel_wr = hit && !addr[0];
   assign dat_wr = hit && addr[0];

   always_ff @(posedge clk) begin
      if (rst) begin
         idx_q <= '0;
         inv_q <= 1'b0;
      end else if (sel_wr) begin
         idx_q <= data[IW-1:0];
         inv_q <= data[DW-1];
      end
   end

   for (genvar g = 0; g < NREG; g++) begin : g_bank
      always_ff @(posedge clk) begin
         if (rst) begin
            bank_q[g] <= '0;
         end else if (dat_wr && idx_q == IW'(g)) begin
            bank_q[g].ram <= data[CSB];
            bank_q[g].num <= data[BANK_W-1:0];
         end
      end

      assert_bank_load_R3: assert property (@(posedge clk) disable iff (rst)
         (dat_wr && idx_q == IW'(g)) |=>
            (bank_q[g] == {$past(data[CSB]), $past(data[BANK_W-1:0])}));
   end

   assert_sel_load_R2: assert property (@(posedge clk) disable iff (rst)
      sel_wr |=> (inv_q == $past(data[DW-1]) && idx_q == $past(data[IW-1:0])));

   assert_spare_idx_R4: assert property (@(posedge clk) disable iff (rst)
      (dat_wr && idx_q >= IW'(NREG)) |=> ($stable(bank_q) && $stable(inv_q)));

   assert_range_gate_R1: assert property (@(posedge clk) disable iff (rst)
      !hit |=> ($stable(bank_q) && $stable(inv_q) && $stable(idx_q)));
endmodule

// File: rtl/chr_window_map.sv
module chr_window_map
   import chr_map_pkg::*;
#(
   parameter int unsigned VW = VID_W,
   parameter int unsigned WW = WIN_W,
   parameter int unsigned IW = IDX_W
) (
   input  logic [VW-1:0] vid_addr,
   input  logic          inv,
   output logic [IW-1:0] reg_idx,
   output logic          wide
);
   logic half;

   initial begin
      assert (VW == WW + 4) else $error("video width must cover 8 KB of windows plus A13");
   end

   assign half = vid_addr[WW+2] ^ inv;

   always_comb begin
      if (!half) begin
         wide    = 1'b1;
         reg_idx = IW'(vid_addr[WW+1]);
      end else begin
         wide    = 1'b0;
         reg_idx = IW'(2) + IW'(vid_addr[WW+1:WW]);
      end
   end
endmodule

// File: rtl/chr_addr_xlate.sv
module chr_addr_xlate
   import chr_map_pkg::*;
#(
   parameter int unsigned VW = VID_W,
   parameter int unsigned WW = WIN_W,
   parameter int unsigned BW = BANK_W
) (
   input  logic             clk,
   input  logic             rst,
   input  chr_bank_t        bank,
   input  logic             wide,
   input  logic [VW-1:0]    vid_addr,
   output logic [BW+WW-1:0] chr_addr,
   output logic             rom_ce,
   output logic             ram_ce
);
   logic in_pat;

   assign in_pat = !vid_addr[VW-1];

   always_comb begin
      if (wide) chr_addr = {bank.num[BW-1:1], vid_addr[WW], vid_addr[WW-1:0]};
      else      chr_addr = {bank.num, vid_addr[WW-1:0]};
   end

   assign rom_ce = in_pat && !bank.ram;
   assign ram_ce = in_pat &&  bank.ram;

   assert_ce_excl_R8: assert property (@(posedge clk) disable iff (rst)
      !(rom_ce && ram_ce));

   assert_nt_quiet_R9: assert property (@(posedge clk) disable iff (rst)
      vid_addr[VW-1] |-> (!rom_ce && !ram_ce));

   assert_offset_pass_R6: assert property (@(posedge clk) disable iff (rst)
      chr_addr[WW-1:0] == vid_addr[WW-1:0]);
endmodule

// File: rtl/chr_bank_mapper.sv
module chr_bank_mapper
   import chr_map_pkg::*;
#(
   parameter int unsigned NREG = CHR_REGS,
   parameter int unsigned VW   = VID_W,
   parameter int unsigned WW   = WIN_W,
   parameter int unsigned BW   = BANK_W,
   localparam int unsigned AW  = BW + WW
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          cpu_we,
   input  logic [15:0]   cpu_addr,
   input  logic [7:0]    cpu_data,
   input  logic [VW-1:0] vid_addr,
   output logic [AW-1:0] chr_addr,
   output logic          rom_ce,
   output logic          ram_ce
);
   chr_bank_t [NREG-1:0] bank_q;
   chr_bank_t            bank_sel;
   logic                 inv_q, wide;
   logic [IDX_W-1:0]     reg_idx;

   chr_bank_regs #(.NREG(NREG)) i_regs (
      .clk(clk), .rst(rst), .we(cpu_we), .addr(cpu_addr), .data(cpu_data),
      .bank_q(bank_q), .inv_q(inv_q)
   );

   chr_window_map #(.VW(VW), .WW(WW)) i_map (
      .vid_addr(vid_addr), .inv(inv_q), .reg_idx(reg_idx), .wide(wide)
   );

   always_comb begin
      bank_sel = '0;
      for (int k = 0; k < NREG; k++)
         if (reg_idx == IDX_W'(k)) bank_sel = bank_q[k];
   end

   chr_addr_xlate #(.VW(VW), .WW(WW), .BW(BW)) i_xlate (
      .clk(clk), .rst(rst), .bank(bank_sel), .wide(wide), .vid_addr(vid_addr),
      .chr_addr(chr_addr), .rom_ce(rom_ce), .ram_ce(ram_ce)
   );
endmodule

// File: tb/test_chr_bank_mapper.sv
`timescale 1ns/1ps
module test_chr_bank_mapper;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic [13:0] vid_addr = '0;
   logic [15:0] chr_addr;
   logic        rom_ce, ram_ce;

   int vectors = 0;
   int errors  = 0;
   int bank_m [0:7];
   int idx_m = 0;
   int inv_m = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   chr_bank_mapper i_chr_bank_mapper (
      .clk(clk), .rst(rst), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
      .vid_addr(vid_addr), .chr_addr(chr_addr), .rom_ce(rom_ce), .ram_ce(ram_ce)
   );

   task automatic compare(input string req);
      int v, s, b, ea, erom, eram;
      v = int'(vid_addr);
      s = (v >> 10) & 7;
      if (inv_m != 0) s = s ^ 4;
      if (s < 4) begin
         b  = bank_m[s >> 1];
         ea = ((b & 'h3E) << 10) | (v & 'h7FF);
      end else begin
         b  = bank_m[s - 2];
         ea = ((b & 'h3F) << 10) | (v & 'h3FF);
      end
      erom = ((v >> 13) == 0 && ((b >> 6) & 1) == 0) ? 1 : 0;
      eram = ((v >> 13) == 0 && ((b >> 6) & 1) == 1) ? 1 : 0;
      vectors++;
      if (int'(chr_addr) != ea || int'(rom_ce) != erom || int'(ram_ce) != eram) begin
         errors++;
         $display("FAIL %s vid=%h: addr/rom/ram actual %h/%0d/%0d expected %h/%0d/%0d",
                  req, v, chr_addr, rom_ce, ram_ce, ea, erom, eram);
      end
   endtask

   task automatic apply(input bit we, input int a, input int d, input int v, input string req);
      @(negedge clk);
      cpu_we = we; cpu_addr = 16'(a); cpu_data = 8'(d); vid_addr = 14'(v);
      #2 compare(req);
      @(posedge clk);
      if (we && a >= 'h8000 && a <= 'h9FFF) begin
         if ((a & 1) == 0) begin
            idx_m = d & 7;
            inv_m = (d >> 7) & 1;
         end else if (idx_m < 6) begin
            bank_m[idx_m] = d & 'h7F;
         end
      end
   endtask

   task automatic sweep(input string req);
      for (int v = 0; v < 16384; v += 96) apply(1'b0, 0, 0, v, req);
   endtask

   task automatic wr(input int a, input int d, input string req);
      apply(1'b1, a, d, int'($urandom) & 'h3FFF, req);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) bank_m[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 1'b0;
      // R10: reset state, every window in ROM bank 0
      sweep("R10");
      // R2 / R3: load all six registers, normal mode; R5, R6, R8 by sweep
      wr('h8000, 0, "R2"); wr('h8001, 'h2B, "R3");
      wr('h8002, 1, "R2"); wr('h9FFF, 'h55, "R3");
      wr('h9FFE, 2, "R2"); wr('h8003, 'h81, "R3");
      wr('h8004, 3, "R2"); wr('h8005, 'h7F, "R3");
      wr('h8006, 4, "R2"); wr('h9001, 'h12, "R3");
      wr('h8008, 5, "R2"); wr('h8009, 'h4C, "R3");
      sweep("R5");
      sweep("R6");
      sweep("R8");
      // R7: inversion flag set
      wr('h8000, 'h80, "R7");
      sweep("R7");
      wr('h8000, 'h83, "R7"); wr('h8001, 'hFE, "R3");
      sweep("R7");
      // R4: indices 6 and 7 must not disturb character state
      wr('h8000, 6, "R4"); wr('h8001, 'h3F, "R4");
      wr('h8000, 7, "R4"); wr('h8001, 'h7A, "R4");
      sweep("R4");
      // R1: writes outside $8000-$9FFF ignored
      wr('h8000, 'h02, "R1");
      wr('h7FFF, 'h44, "R1"); wr('hA001, 'h44, "R1"); wr('hA000, 'h80, "R1");
      wr('hC001, 'h44, "R1"); wr('h0001, 'h44, "R1"); wr('hFFFE, 'h85, "R1");
      sweep("R1");
      // R9: nametable region
      for (int v = 'h2000; v < 'h4000; v += 64) apply(1'b0, 0, 0, v, "R9");
      // R11: random writes interleaved with lookups, checked each clock
      for (int n = 0; n < 3000; n++) begin
         int a;
         a = int'($urandom) & 'hFFFF;
         if (($urandom & 3) != 0) a = 'h8000 | (a & 'h1FFF);
         apply(1'($urandom & 1), a, int'($urandom) & 'hFF, int'($urandom) & 'h3FFF, "R11");
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule